// File: doc/BRIEF.md
# Serial Controller Host Bus Adapter

This block connects a host processor bus to a two-channel serial communications controller. The host side has an address latch enable, read and write strobes, an interrupt-acknowledge status line, a reset line and a byte address. The controller side has a chip select, two strobe lines, channel and data/command selects, and a transmit DMA request.

The controller can be driven in either of two bus styles. In multiplexed style one line carries address strobes and the other carries data strobes. In non-multiplexed style the two lines carry separate read and write strobes. The block picks the style at run time. Any rising edge on the latch-enable input selects multiplexed style until the next block reset. A latch-enable input that stays low keeps the default non-multiplexed style.

The host performs two acknowledge cycles for each interrupt. The block turns these into the single acknowledge access the controller expects. Host writes are held back until write data is valid. The host reset line pulls both strobe lines active. The controller's transmit DMA request is released early whenever the host writes channel B's data register.

Top module: `scc_bus_glue`

## Requirements
- R1: After `rst_n` is low at a clock edge, `mux_mode` is 0. At the first clock edge that sees `host_ale` high after it was low, `mux_mode` becomes 1 and stays 1 until `rst_n` is low again.
- R2: In multiplexed style (`mux_mode` 1, or `host_ale` high), `scc_as_rd_n` is the inverse of `host_ale`, except during a second acknowledge cycle. `scc_ds_wr_n` goes low for a selected read, a delayed write, or a second acknowledge cycle.
- R3: In non-multiplexed style, `scc_as_rd_n` is low while `host_rd_n` is low to a selected address.
- R4: In non-multiplexed style, `scc_ds_wr_n` goes low only after `WR_DELAY` rising clock edges have seen `host_wr_n` low to a selected address. It returns high in the same cycle that `host_wr_n` returns high.
- R5: While `host_reset` is 1, both `scc_as_rd_n` and `scc_ds_wr_n` are 0, whatever the mode.
- R6: A selected address is even and lies in `BASE_ADDR` .. `BASE_ADDR`+127, where `BASE_ADDR` is 128-byte aligned. `scc_cs_n` is 0 only while `host_rd_n` or `host_wr_n` is low to a selected address and `host_inta_n` is high.
- R7: `scc_chan_a` follows address bit 2 (1 = channel A). `scc_data_sel` follows address bit 1 (1 = data register). Offsets modulo 8 select the registers as follows: 0 = B command, 2 = B data, 4 = A command, 6 = A data.
- R8: An acknowledge cycle is `host_inta_n` low. In the first cycle, neither read nor data strobe is issued and the address strobe follows `host_ale`. In the second cycle, the address strobe is held high, and the read strobe (non-multiplexed) or data strobe (multiplexed) is low for as long as `host_inta_n` is low. The phase toggles at the end of each acknowledge cycle.
- R9: The acknowledge phase returns to "first" on `rst_n` and after the end of any read or write cycle (rising `host_rd_n` or `host_wr_n` with `host_inta_n` high).
- R10: `dma_txreq_n` equals `scc_txreq_n` with one exception. It is forced to 1 in the same cycle that a host write to offset 2 (channel B data) begins. It stays 1 until the write has ended and `scc_txreq_n` has been seen high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| host_ale | input | 1 | Host address latch enable, also the style strap |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_inta_n | input | 1 | Host interrupt-acknowledge status, active low |
| host_reset | input | 1 | Host reset, active high, merged onto both strobes |
| host_addr | input | ADDR_W | Host byte address |
| scc_txreq_n | input | 1 | Raw transmit DMA request from the controller, active low |
| scc_cs_n | output | 1 | Controller chip select, active low |
| scc_as_rd_n | output | 1 | Address strobe (multiplexed) or read strobe (non-multiplexed) |
| scc_ds_wr_n | output | 1 | Data strobe (multiplexed) or write strobe (non-multiplexed) |
| scc_chan_a | output | 1 | Channel select, 1 = channel A |
| scc_data_sel | output | 1 | Register select, 1 = data, 0 = command/status |
| dma_txreq_n | output | 1 | Clipped transmit DMA request, active low |
| mux_mode | output | 1 | Detected bus style, 1 = multiplexed |

## Verification
The assertions check four behaviours on every cycle: that the detected style never falls back without a reset, that host reset forces both strobes low, that chip select never reaches an odd or out-of-window address, and that the delayed write strobe never outlives or precedes the host write. They also check that the clipped request is never active during a channel B data write or without the raw request. Only the bench scenarios can show the run-time sequences: the exact delay count of the write, the alternation of acknowledge phases and their reset by an ordinary cycle, and the rule that the clipped request waits for the raw request to go high before following it again.

// File: rtl/scc_glue_pkg.sv
// Shared types and constants for the serial controller bus adapter.
// Assumes the register window is 128 bytes and naturally aligned.
package scc_glue_pkg;
    // Address bits spanned by the controller's register window.
    localparam int WIN_BITS = 7;

    // Phase of the host's double acknowledge sequence.
    typedef enum logic {
        ACK_FIRST  = 1'b0,
        ACK_SECOND = 1'b1
    } ack_phase_e;
endpackage

// File: rtl/scc_mode_detect.sv
// Detects the bus style from activity on the latch-enable strap.
// Assumes the strap is synchronous to clk. Non-multiplexed is the default.
module scc_mode_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ale,
    output logic mux_mode
);
    logic ale_q;
    logic mux_q;

    // Sticky style flag, set on the first rising edge of the strap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_q <= 1'b0;
            mux_q <= 1'b0;
        end else begin
            ale_q <= ale;
            mux_q <= mux_q | (ale & ~ale_q);
        end
    end

    assign mux_mode = mux_q;
endmodule

// File: rtl/scc_ack_track.sv
// Tracks which of the host's two acknowledge cycles is in progress.
// An acknowledge cycle is inta_n low. Any completed read or write re-aligns the tracker.
module scc_ack_track
    import scc_glue_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inta_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic second
);
    ack_phase_e phase_q;
    logic       inta_q;
    logic       rd_q;
    logic       wr_q;
    logic       ack_end;
    logic       bus_end;

    assign ack_end = ~inta_q & inta_n;
    assign bus_end = inta_n & ((~rd_q & rd_n) | (~wr_q & wr_n));

    // Phase register: cleared by ordinary cycles, toggled by acknowledge ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= ACK_FIRST;
            inta_q  <= 1'b1;
            rd_q    <= 1'b1;
            wr_q    <= 1'b1;
        end else begin
            inta_q <= inta_n;
            rd_q   <= rd_n;
            wr_q   <= wr_n;
            if (bus_end)
                phase_q <= ACK_FIRST;
            else if (ack_end)
                phase_q <= (phase_q == ACK_FIRST) ? ACK_SECOND : ACK_FIRST;
        end
    end

    assign second = (phase_q == ACK_SECOND);
endmodule

// File: rtl/scc_wr_delay.sv
// Holds back the controller write strobe until host data has had DELAY clock edges to settle.
// The strobe ends combinationally with the request, so it never outlasts the host write.
module scc_wr_delay #(
    parameter int DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    output logic wr_go
);
    localparam int CNT_W = (DELAY < 1) ? 1 : $clog2(DELAY + 1);

    generate
        if (DELAY == 0) begin : g_pass
            assign wr_go = wr_req;
        end else begin : g_count
            logic [CNT_W-1:0] cnt_q;

            // Saturating count of edges seen with the request held.
            always_ff @(posedge clk) begin
                if (!rst_n || !wr_req)
                    cnt_q <= '0;
                else if (cnt_q != CNT_W'(DELAY))
                    cnt_q <= cnt_q + 1'b1;
            end

            assign wr_go = wr_req & (cnt_q == CNT_W'(DELAY));
        end
    endgenerate
endmodule

// File: rtl/scc_dma_clip.sv
// Releases the transmit DMA request early when the host writes the channel data register.
// Holds the request off until the write ends and the raw request has been seen inactive.
module scc_dma_clip (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_req_n,
    input  logic data_wr,
    input  logic host_wr_n,
    output logic req_n
);
    logic blk_q;

    // Block flag: set by the data write, cleared once the write is over and raw has gone high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            blk_q <= 1'b0;
        else if (data_wr)
            blk_q <= 1'b1;
        else if (host_wr_n && raw_req_n)
            blk_q <= 1'b0;
    end

    assign req_n = raw_req_n | data_wr | blk_q;
endmodule

// File: rtl/scc_bus_glue.sv
// Top of the host-to-serial-controller adapter: address decode, strobe steering,
// reset merge, acknowledge splitting and DMA request clipping.
// Assumes all host inputs are synchronous to clk and BASE_ADDR is 128-byte aligned.
module scc_bus_glue
    import scc_glue_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0100,
    parameter int              WR_DELAY  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_ale,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic              host_inta_n,
    input  logic              host_reset,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              scc_txreq_n,
    output logic              scc_cs_n,
    output logic              scc_as_rd_n,
    output logic              scc_ds_wr_n,
    output logic              scc_chan_a,
    output logic              scc_data_sel,
    output logic              dma_txreq_n,
    output logic              mux_mode
);
    localparam int TAG_W = ADDR_W - WIN_BITS;

    logic hit;
    logic rd_sel;
    logic wr_sel;
    logic wr_go;
    logic ack_second;
    logic ack2;
    logic mux_now;
    logic as_on;
    logic ds_on;
    logic data_wr_b;

    // Address decode: even locations inside the aligned window.
    assign hit = (host_addr[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS])
               && !host_addr[0];
    assign rd_sel = hit & ~host_rd_n & host_inta_n;
    assign wr_sel = hit & ~host_wr_n & host_inta_n;
    assign scc_cs_n     = ~(rd_sel | wr_sel);
    assign scc_chan_a   = host_addr[2];
    assign scc_data_sel = host_addr[1];
    assign data_wr_b    = wr_sel & (host_addr[2:1] == 2'b01);

    scc_mode_detect u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .ale      (host_ale),
        .mux_mode (mux_mode)
    );

    scc_ack_track u_ack (
        .clk    (clk),
        .rst_n  (rst_n),
        .inta_n (host_inta_n),
        .rd_n   (host_rd_n),
        .wr_n   (host_wr_n),
        .second (ack_second)
    );

    scc_wr_delay #(.DELAY(WR_DELAY)) u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_req (wr_sel),
        .wr_go  (wr_go)
    );

    scc_dma_clip u_dma (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_req_n (scc_txreq_n),
        .data_wr   (data_wr_b),
        .host_wr_n (host_wr_n),
        .req_n     (dma_txreq_n)
    );

    // Strobe steering per bus style, with host reset forcing both lines active.
    assign ack2    = ~host_inta_n & ack_second;
    assign mux_now = mux_mode | host_ale;
    assign as_on   = host_ale & ~ack2;
    assign ds_on   = rd_sel | wr_go | ack2;

    always_comb begin
        if (host_reset) begin
            scc_as_rd_n = 1'b0;
            scc_ds_wr_n = 1'b0;
        end else if (mux_now) begin
            scc_as_rd_n = ~as_on;
            scc_ds_wr_n = ~ds_on;
        end else begin
            scc_as_rd_n = ~(rd_sel | ack2);
            scc_ds_wr_n = ~wr_go;
        end
    end

    logic [TAG_W-1:0] unused_tag;
    assign unused_tag = BASE_ADDR[ADDR_W-1:WIN_BITS];
endmodule

// File: rtl/scc_bus_glue_chk.sv
// Cycle-by-cycle property checker for scc_bus_glue, attached by bind.
module scc_bus_glue_chk #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr_n,
    input logic              host_reset,
    input logic [ADDR_W-1:0] host_addr,
    input logic              scc_txreq_n,
    input logic              scc_cs_n,
    input logic              scc_as_rd_n,
    input logic              scc_ds_wr_n,
    input logic              dma_txreq_n,
    input logic              mux_mode
);
    assert_mode_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mux_mode |=> mux_mode);

    assert_reset_merge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_reset |-> (!scc_as_rd_n && !scc_ds_wr_n));

    assert_cs_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !scc_cs_n |-> (!host_addr[0] && host_addr[ADDR_W-1:7] == BASE_ADDR[ADDR_W-1:7]));

    assert_wr_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mux_mode && host_wr_n && !host_reset) |-> scc_ds_wr_n);

    assert_wr_late_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mux_mode && !host_reset && !host_wr_n && $fell(scc_ds_wr_n)) |-> $past(!host_wr_n));

    assert_dma_clip_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr_n && !scc_cs_n && host_addr[2:1] == 2'b01) |-> dma_txreq_n);

    assert_dma_raw_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_txreq_n |-> !scc_txreq_n);
endmodule

bind scc_bus_glue scc_bus_glue_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr_n   (host_wr_n),
    .host_reset  (host_reset),
    .host_addr   (host_addr),
    .scc_txreq_n (scc_txreq_n),
    .scc_cs_n    (scc_cs_n),
    .scc_as_rd_n (scc_as_rd_n),
    .scc_ds_wr_n (scc_ds_wr_n),
    .dma_txreq_n (dma_txreq_n),
    .mux_mode    (mux_mode)
);

// File: tb/scc_bus_glue_tb.sv
// Self-checking bench: decode vector table, then directed sequences.
module scc_bus_glue_tb_top;
    localparam int NV = 9;
    // {addr[15:0], rd_n, exp cs_n, exp chan_a, exp data_sel, exp as_rd_n}
    localparam logic [20:0] VEC [NV] = '{
        {16'h0100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {16'h0102, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {16'h0104, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {16'h0106, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {16'h017E, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {16'h0101, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        {16'h0180, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        {16'h00FE, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        {16'h0104, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1, inta_n = 1'b1, hreset = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic raw_n = 1'b1;
    logic cs_n, as_rd_n, ds_wr_n, chan_a, data_sel, dma_n, mux;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    scc_bus_glue #(.ADDR_W(16), .BASE_ADDR(16'h0100), .WR_DELAY(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_ale(ale), .host_rd_n(rd_n), .host_wr_n(wr_n),
        .host_inta_n(inta_n), .host_reset(hreset), .host_addr(addr), .scc_txreq_n(raw_n),
        .scc_cs_n(cs_n), .scc_as_rd_n(as_rd_n), .scc_ds_wr_n(ds_wr_n), .scc_chan_a(chan_a),
        .scc_data_sel(data_sel), .dma_txreq_n(dma_n), .mux_mode(mux)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%b exp=%b t=%0t", tag, got, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // Reset state (R1, R6, R10)
        chk("R1 reset mux_mode", mux, 1'b0);
        chk("R6 reset cs_n", cs_n, 1'b1);
        chk("R3 reset as_rd_n", as_rd_n, 1'b1);
        chk("R4 reset ds_wr_n", ds_wr_n, 1'b1);
        chk("R10 reset dma", dma_n, 1'b1);

        // Decode table, non-multiplexed reads (R3, R6, R7)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            addr = VEC[i][20:5];
            rd_n = VEC[i][4];
            #1;
            chk("R6 table cs_n", cs_n, VEC[i][3]);
            chk("R7 table chan_a", chan_a, VEC[i][2]);
            chk("R7 table data_sel", data_sel, VEC[i][1]);
            chk("R3 table as_rd_n", as_rd_n, VEC[i][0]);
            @(negedge clk);
            rd_n = 1'b1;
        end

        // Host reset merge (R5)
        @(negedge clk); hreset = 1'b1; #1;
        chk("R5 as_rd_n", as_rd_n, 1'b0);
        chk("R5 ds_wr_n", ds_wr_n, 1'b0);
        @(negedge clk); hreset = 1'b0; #1;
        chk("R5 release", as_rd_n & ds_wr_n, 1'b1);

        // Delayed write, non-multiplexed (R4)
        @(negedge clk); addr = 16'h0104; wr_n = 1'b0; #1;
        chk("R4 wr cs_n", cs_n, 1'b0);
        chk("R4 wr edge0", ds_wr_n, 1'b1);
        @(negedge clk); #1; chk("R4 wr edge1", ds_wr_n, 1'b1);
        @(negedge clk); #1; chk("R4 wr edge2", ds_wr_n, 1'b0);
        @(negedge clk); wr_n = 1'b1; #1; chk("R4 wr end", ds_wr_n, 1'b1);

        // DMA clip (R10)
        @(negedge clk); raw_n = 1'b0; #1; chk("R10 raw follow", dma_n, 1'b0);
        @(negedge clk); addr = 16'h0106; wr_n = 1'b0; #1; chk("R10 A data no clip", dma_n, 1'b0);
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); addr = 16'h0102; wr_n = 1'b0; #1; chk("R10 clip at start", dma_n, 1'b1);
        @(negedge clk); wr_n = 1'b1; #1; chk("R10 held after write", dma_n, 1'b1);
        @(negedge clk); #1; chk("R10 held raw low", dma_n, 1'b1);
        raw_n = 1'b1;
        @(negedge clk); raw_n = 1'b0; #1; chk("R10 follows again", dma_n, 1'b0);
        @(negedge clk); raw_n = 1'b1;

        // Acknowledge pairs, non-multiplexed (R8, R9)
        @(negedge clk); inta_n = 1'b0; #1;
        chk("R8 ack1 no rd", as_rd_n, 1'b1);
        chk("R8 ack1 no cs", cs_n, 1'b1);
        @(negedge clk); inta_n = 1'b1;
        @(negedge clk); inta_n = 1'b0; #1; chk("R8 ack2 rd", as_rd_n, 1'b0);
        @(negedge clk); inta_n = 1'b1;
        @(negedge clk); inta_n = 1'b0; #1; chk("R8 next ack1", as_rd_n, 1'b1);
        @(negedge clk); inta_n = 1'b1;
        @(negedge clk); addr = 16'h0100; rd_n = 1'b0;
        @(negedge clk); rd_n = 1'b1;
        @(negedge clk); inta_n = 1'b0; #1; chk("R9 realign after read", as_rd_n, 1'b1);
        @(negedge clk); inta_n = 1'b1;

        // Mode detection and multiplexed strobes (R1, R2)
        @(negedge clk); ale = 1'b1; #1;
        chk("R2 first AS", as_rd_n, 1'b0);
        chk("R1 not yet", mux, 1'b0);
        @(negedge clk); ale = 1'b0; #1;
        chk("R1 latched", mux, 1'b1);
        chk("R2 AS end", as_rd_n, 1'b1);
        @(negedge clk); addr = 16'h0104; rd_n = 1'b0; #1;
        chk("R2 DS read", ds_wr_n, 1'b0);
        chk("R2 no RD on AS line", as_rd_n, 1'b1);
        @(negedge clk); rd_n = 1'b1;
        @(negedge clk); wr_n = 1'b0; #1; chk("R2 DS write delayed", ds_wr_n, 1'b1);
        @(negedge clk); @(negedge clk); #1; chk("R2 DS write", ds_wr_n, 1'b0);
        @(negedge clk); wr_n = 1'b1;

        // Multiplexed acknowledge split (R8)
        @(negedge clk); inta_n = 1'b0; ale = 1'b1; #1;
        chk("R8 mux ack1 AS", as_rd_n, 1'b0);
        chk("R8 mux ack1 no DS", ds_wr_n, 1'b1);
        @(negedge clk); ale = 1'b0; inta_n = 1'b1;
        @(negedge clk); inta_n = 1'b0; ale = 1'b1; #1;
        chk("R8 mux ack2 no AS", as_rd_n, 1'b1);
        chk("R8 mux ack2 DS", ds_wr_n, 1'b0);
        @(negedge clk); ale = 1'b0; inta_n = 1'b1;

        // Block reset clears style (R1)
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R1 cleared by reset", mux, 1'b0);
        @(negedge clk); #1; chk("R1 stays clear", mux, 1'b0);

        finish_run();
    end
endmodule